// File: doc/BRIEF.md
# Decimating Row/Column Readout Sequencer

This block steps through the row and column addresses of a pixel array for readout, with optional decimation. One control byte selects, separately for rows and for columns, whether every line is read or only one line unit out of every 2, 4 or 8. A mode bit sets the size of that line unit. In monochrome mode a unit is one line. In colour mosaic mode a unit is two adjacent lines, so decimation keeps or drops whole 2x2 colour cells and the colour pattern survives.

A controller writes the control byte at any time. The sequencer copies it, together with the array width and height, when a frame starts, so the addresses of a frame never change partway through. When a row is about to begin, the sequencer raises a row-valid flag and waits for a row-ready handshake. It then offers one column address at a time and moves to the next column on each column-ready. End-of-row marks the last column emitted in a row. End-of-frame marks the last pixel of the frame. After that pixel the sequencer stays idle until the next start pulse.

Top module: `subsamp_addr_gen`

## Requirements
- R1: Reset is synchronous and active low. During and after reset, row_valid, pix_valid, end_of_row and end_of_frame are low. The held control value resets to 10h, so a frame started with no prior write uses colour mosaic mode with every row and every column read.
- R2: Control bits 3:2 set the row decimation in line units. 00 reads every unit. 01 reads one unit and skips one. 10 reads one and skips three. 11 reads one and skips seven.
- R3: Control bits 1:0 set the column decimation with the same four codes as R2. They apply to columns independently of the row setting.
- R4: Control bit 4 selects the line unit. With 1 (colour mosaic), address a is emitted when (a/2) mod k is 0, which gives rows 0,1,4,5,... for k=2. With 0 (monochrome), address a is emitted when a mod k is 0. Here k = 1, 2, 4 or 8 from the field.
- R5: Control bits 7:5 are ignored. A byte that differs from another only in those bits produces the same address sequence.
- R6: A control write takes effect at the next frame start. A write in the same cycle as the start pulse applies to that frame. A write during a frame leaves that frame unchanged and applies to the following one.
- R7: After a start, and again after each completed row, row_valid is high and pix_valid is low until row_ready is seen. While pix_valid is high and col_ready is low, col_addr and row_addr hold.
- R8: end_of_row is high together with the last emitted column of each row. end_of_frame is high only with the last emitted column of the last emitted row.
- R9: Once the end-of-frame pixel is accepted, row_valid and pix_valid stay low until the next start. A start pulse during a frame is ignored.
- R10: No row address at or above the height and no column address at or above the width is emitted. This holds when a size is odd and the last colour unit is only partly inside the array. Sizes are at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the control byte |
| cfg_data | input | 8 | Control byte: bit 4 mode, bits 3:2 row decimation, bits 1:0 column decimation |
| array_width | input | ADDR_W | Number of columns, copied at frame start |
| array_height | input | ADDR_W | Number of rows, copied at frame start |
| start | input | 1 | Starts a frame when the sequencer is idle |
| row_ready | input | 1 | Lets the pending row begin |
| col_ready | input | 1 | Accepts the offered column address |
| row_addr | output | ADDR_W | Current row address |
| col_addr | output | ADDR_W | Current column address |
| row_valid | output | 1 | A row is pending or in progress |
| pix_valid | output | 1 | col_addr and row_addr name a pixel to read |
| end_of_row | output | 1 | Offered column is the last of its row |
| end_of_frame | output | 1 | Offered pixel is the last of the frame |

## Verification
Two events can land in the same clock cycle: a control-byte write and the frame-start capture. The bench drives cfg_wr and start in one cycle and checks that the whole frame follows the newly written byte, not the byte held before it. It also drives a write and a start pulse together while a frame is running. It then checks that the running frame keeps its original sequence, and that the following frame, started with no write, uses the mid-frame value.

// File: rtl/subsamp_pkg.sv
// Shared types for the decimating readout sequencer.
// Assumes: the control byte layout is bit 4 unit mode, bits 3:2 row
// decimation, bits 1:0 column decimation; bits 7:5 carry no meaning.
package subsamp_pkg;

    typedef struct packed {
        logic       bayer;     // 1: two-line unit, 0: single-line unit
        logic [1:0] row_freq;  // log2 of row unit stride
        logic [1:0] col_freq;  // log2 of column unit stride
    } ss_cfg_t;

    localparam logic [7:0] SS_CFG_RESET = 8'h10;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ROW  = 2'd1,
        SEQ_COLS = 2'd2
    } seq_state_t;

    // Extracts the meaningful fields of a control byte; bits 7:5 dropped.
    function automatic ss_cfg_t ss_decode(input logic [7:0] b);
        ss_cfg_t c;
        c.bayer    = b[4];
        c.row_freq = b[3:2];
        c.col_freq = b[1:0];
        return c;
    endfunction

endpackage

// File: rtl/ss_cfg_reg.sv
// Control holding register plus per-frame active copy.
// The staged copy follows every write; the active copy is loaded only when
// a frame starts, and a write in the start cycle is taken directly.
// Assumes: load is a single-cycle pulse from the sequencer.
module ss_cfg_reg
    import subsamp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       load,
    output ss_cfg_t    active
);

    ss_cfg_t staged;
    ss_cfg_t load_val;

    // Value the active copy takes at a frame start.
    always_comb begin
        load_val = wr_en ? ss_decode(wr_data) : staged;
    end

    // Staged copy: tracks controller writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= ss_decode(SS_CFG_RESET);
        end else if (wr_en) begin
            staged <= ss_decode(wr_data);
        end
    end

    // Active copy: frozen for the duration of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= ss_decode(SS_CFG_RESET);
        end else if (load) begin
            active <= load_val;
        end
    end

    assert_active_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(active));

endmodule

// File: rtl/ss_addr_step.sv
// One-dimensional decimating address counter.
// Emits addresses whose line unit index is a multiple of 2**freq; a unit is
// one line (bayer=0) or two lines (bayer=1). 'last' tells that no further
// address exists below size.
// Assumes: size >= 1; the owner clears on the last address and never
// advances past it; bayer, freq and size are stable between clears.
module ss_addr_step #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic              bayer,
    input  logic [1:0]        freq,
    input  logic [ADDR_W-1:0] size,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    localparam int NW = ADDR_W + 1;

    logic          phase;      // second line of a two-line unit
    logic [NW-1:0] span_m1;    // unit stride minus one, in units
    logic [NW-1:0] jump;       // extra distance beyond +1
    logic [NW-1:0] next_addr;
    logic          next_phase;

    // Next address: +1 inside a unit, skip the dropped units at its end.
    always_comb begin
        span_m1 = (NW'(1) << freq) - NW'(1);
        if (bayer) begin
            jump = phase ? (span_m1 << 1) : '0;
        end else begin
            jump = span_m1;
        end
        next_addr  = {1'b0, addr} + NW'(1) + jump;
        next_phase = bayer ? ~phase : 1'b0;
        last       = next_addr >= {1'b0, size};
    end

    // Address register and unit phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            addr  <= '0;
            phase <= 1'b0;
        end else if (advance) begin
            addr  <= next_addr[ADDR_W-1:0];
            phase <= next_phase;
        end
    end

    assert_step_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear) |=> (addr > $past(addr)));

    assert_no_step_past_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear) |-> !last);

endmodule

// File: rtl/subsamp_addr_gen.sv
// Decimating readout address sequencer (top).
// Walks rows, then columns inside each row, emitting only the addresses
// that the active control value keeps. Rows wait for row_ready, columns
// advance on col_ready. Control, width and height are sampled at start.
// Assumes: array_width and array_height are at least 1.
module subsamp_addr_gen
    import subsamp_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_data,
    input  logic [ADDR_W-1:0] array_width,
    input  logic [ADDR_W-1:0] array_height,
    input  logic              start,
    input  logic              row_ready,
    input  logic              col_ready,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic              row_valid,
    output logic              pix_valid,
    output logic              end_of_row,
    output logic              end_of_frame
);

    seq_state_t        state;
    seq_state_t        state_nx;
    ss_cfg_t           cfg_act;
    logic [ADDR_W-1:0] width_q;
    logic [ADDR_W-1:0] height_q;
    logic              frame_go;
    logic              row_fire;
    logic              col_fire;
    logic              col_last;
    logic              row_last;
    logic              col_clear;
    logic              col_adv;
    logic              row_adv;

    // Handshake decode for the current state.
    always_comb begin
        frame_go  = (state == SEQ_IDLE) && start;
        row_fire  = (state == SEQ_ROW) && row_ready;
        col_fire  = (state == SEQ_COLS) && col_ready;
        col_clear = frame_go || (col_fire && col_last);
        col_adv   = col_fire && !col_last;
        row_adv   = col_fire && col_last && !row_last;
    end

    ss_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_data),
        .load    (frame_go),
        .active  (cfg_act)
    );

    ss_addr_step #(.ADDR_W(ADDR_W)) u_col (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (col_clear),
        .advance (col_adv),
        .bayer   (cfg_act.bayer),
        .freq    (cfg_act.col_freq),
        .size    (width_q),
        .addr    (col_addr),
        .last    (col_last)
    );

    ss_addr_step #(.ADDR_W(ADDR_W)) u_row (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (frame_go),
        .advance (row_adv),
        .bayer   (cfg_act.bayer),
        .freq    (cfg_act.row_freq),
        .size    (height_q),
        .addr    (row_addr),
        .last    (row_last)
    );

    // Array dimensions captured once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q  <= ADDR_W'(1);
            height_q <= ADDR_W'(1);
        end else if (frame_go) begin
            width_q  <= array_width;
            height_q <= array_height;
        end
    end

    // Sequencer next-state choice.
    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE: if (start)     state_nx = SEQ_ROW;
            SEQ_ROW:  if (row_ready) state_nx = SEQ_COLS;
            SEQ_COLS: if (col_ready && col_last)
                          state_nx = row_last ? SEQ_IDLE : SEQ_ROW;
            default:  state_nx = SEQ_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Output flags derived from state and end detection.
    always_comb begin
        row_valid    = (state != SEQ_IDLE);
        pix_valid    = (state == SEQ_COLS);
        end_of_row   = pix_valid && col_last;
        end_of_frame = end_of_row && row_last;
    end

    assert_eof_with_eor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        end_of_frame |-> (end_of_row && pix_valid));

    assert_col_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !col_ready) |=> (pix_valid && $stable(col_addr) && $stable(row_addr)));

    assert_row_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && !pix_valid && !row_ready) |=> !pix_valid);

    assert_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> ((col_addr < width_q) && (row_addr < height_q)));

    assert_idle_after_eof_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && col_ready && end_of_frame) |=> !row_valid);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !col_ready && start) |=> pix_valid);

endmodule

// File: tb/subsamp_addr_gen_tb.sv
`timescale 1ns/1ps
module subsamp_addr_gen_tb;

    localparam int ADDR_W = 10;
    localparam int NVEC   = 10;
    // {control byte, width, height}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h00, 8'd8,  8'd6 },
        {8'h05, 8'd16, 8'd8 },
        {8'h0A, 8'd16, 8'd16},
        {8'h0F, 8'd20, 8'd18},
        {8'h14, 8'd16, 8'd12},
        {8'h18, 8'd9,  8'd17},
        {8'h13, 8'd20, 8'd5 },
        {8'h1B, 8'd18, 8'd11},
        {8'h1C, 8'd7,  8'd9 },
        {8'h11, 8'd9,  8'd3 }
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [7:0]        cfg_data = '0;
    logic [ADDR_W-1:0] array_width = '0;
    logic [ADDR_W-1:0] array_height = '0;
    logic              start = 1'b0;
    logic              row_ready = 1'b0;
    logic              col_ready = 1'b0;
    logic [ADDR_W-1:0] row_addr;
    logic [ADDR_W-1:0] col_addr;
    logic              row_valid;
    logic              pix_valid;
    logic              end_of_row;
    logic              end_of_frame;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    subsamp_addr_gen #(.ADDR_W(ADDR_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_data     (cfg_data),
        .array_width  (array_width),
        .array_height (array_height),
        .start        (start),
        .row_ready    (row_ready),
        .col_ready    (col_ready),
        .row_addr     (row_addr),
        .col_addr     (col_addr),
        .row_valid    (row_valid),
        .pix_valid    (pix_valid),
        .end_of_row   (end_of_row),
        .end_of_frame (end_of_frame)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Keep rule from R4: unit index (a or a/2) is a multiple of 2**f.
    function automatic bit keep(input int a, input bit bayer, input int f);
        int u;
        u = bayer ? (a / 2) : a;
        return (u % (1 << f)) == 0;
    endfunction

    task automatic write_cfg(input logic [7:0] v);
        cfg_wr = 1'b1; cfg_data = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_start(input int w, input int h);
        array_width = ADDR_W'(w); array_height = ADDR_W'(h);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Walks one frame already started; checks every emitted address.
    task automatic run_frame(input logic [7:0] ecfg, input int w, input int h,
                             input bit poke, input logic [7:0] poke_val, input string tag);
        bit bay; int rf; int cf; int lastr; int lastc; bit poked;
        bay = ecfg[4]; rf = int'(ecfg[3:2]); cf = int'(ecfg[1:0]);
        lastr = -1; lastc = -1; poked = 0;
        for (int r = 0; r < h; r++) if (keep(r, bay, rf)) lastr = r;
        for (int c = 0; c < w; c++) if (keep(c, bay, cf)) lastc = c;
        for (int r = 0; r < h; r++) begin
            if (!keep(r, bay, rf)) continue;
            chk(row_valid && !pix_valid, {tag, " R7 row wait"}, int'(pix_valid), 0);
            chk(row_addr == ADDR_W'(r), {tag, " row address"}, int'(row_addr), r);
            row_ready = 1'b1;
            @(negedge clk);
            row_ready = 1'b0;
            for (int c = 0; c < w; c++) begin
                if (!keep(c, bay, cf)) continue;
                chk(pix_valid == 1'b1, {tag, " pix_valid"}, int'(pix_valid), 1);
                chk(col_addr == ADDR_W'(c), {tag, " column address"}, int'(col_addr), c);
                chk(row_addr == ADDR_W'(r), {tag, " row during cols"}, int'(row_addr), r);
                chk(end_of_row == (c == lastc), {tag, " R8 end_of_row"},
                    int'(end_of_row), int'(c == lastc));
                chk(end_of_frame == (c == lastc && r == lastr), {tag, " R8 end_of_frame"},
                    int'(end_of_frame), int'(c == lastc && r == lastr));
                if (poke && !poked) begin
                    cfg_wr = 1'b1; cfg_data = poke_val; start = 1'b1; poked = 1;
                end
                col_ready = 1'b1;
                @(negedge clk);
                col_ready = 1'b0; cfg_wr = 1'b0; start = 1'b0;
            end
        end
        chk(!row_valid && !pix_valid, {tag, " R9 idle after frame"}, int'(row_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk(!row_valid && !pix_valid && !end_of_row && !end_of_frame,
            "R1 outputs in reset", int'(row_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!row_valid && !pix_valid, "R1 outputs after reset", int'(pix_valid), 0);

        // R1: default control is colour mosaic, full sampling
        pulse_start(6, 4);
        run_frame(8'h10, 6, 4, 1'b0, 8'h00, "R1 default");

        // R2 R3 R4 R10: table of decimation settings
        for (int i = 0; i < NVEC; i++) begin
            write_cfg(VEC[i][23:16]);
            pulse_start(int'(VEC[i][15:8]), int'(VEC[i][7:0]));
            run_frame(VEC[i][23:16], int'(VEC[i][15:8]), int'(VEC[i][7:0]),
                      1'b0, 8'h00, "R2 R3 R4 R10 vector");
        end

        // R5: bits 7:5 ignored
        write_cfg(8'hE6);
        pulse_start(12, 9);
        run_frame(8'h06, 12, 9, 1'b0, 8'h00, "R5 reserved E6");
        write_cfg(8'hF0);
        pulse_start(5, 4);
        run_frame(8'h10, 5, 4, 1'b0, 8'h00, "R5 reserved F0");

        // R7: row wait and column stall
        write_cfg(8'h00);
        pulse_start(3, 2);
        for (int k = 0; k < 3; k++) begin
            chk(row_valid && !pix_valid, "R7 holds before row_ready", int'(pix_valid), 0);
            @(negedge clk);
        end
        row_ready = 1'b1;
        @(negedge clk);
        row_ready = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(pix_valid && col_addr == '0, "R7 column holds on stall", int'(col_addr), 0);
            @(negedge clk);
        end
        col_ready = 1'b1;
        @(negedge clk);
        chk(pix_valid && col_addr == ADDR_W'(1), "R7 column advances", int'(col_addr), 1);
        row_ready = 1'b1;
        repeat (10) @(negedge clk);
        row_ready = 1'b0; col_ready = 1'b0;
        chk(!row_valid && !pix_valid, "R7 frame completes", int'(row_valid), 0);

        // R6 R9: write and start during a frame leave it unchanged
        write_cfg(8'h00);
        pulse_start(5, 4);
        run_frame(8'h00, 5, 4, 1'b1, 8'h0F, "R6 R9 mid-frame poke");
        pulse_start(20, 18);
        run_frame(8'h0F, 20, 18, 1'b0, 8'h00, "R6 next frame");

        // R6: write in the start cycle applies to that frame
        @(negedge clk);
        cfg_wr = 1'b1; cfg_data = 8'h05;
        pulse_start(8, 6);
        cfg_wr = 1'b0;
        run_frame(8'h05, 8, 6, 1'b0, 8'h00, "R6 same-cycle write");

        // R9: stays idle without a start
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(!row_valid && !pix_valid, "R9 idle holds", int'(row_valid), 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule